// File: doc/BRIEF.md
# SPI Target Byte Receiver with Keep-Last Buffer

This block is the receive side of an SPI target running in clock mode 0. While the active-low chip-select is held low, each rising edge of the serial clock samples one data bit, most significant bit first. After eight bits the finished byte goes to a single-entry holding register. A full flag marks unread data, and a sticky overflow flag records that a byte arrived while the previous one was still unread.

The three serial inputs are asynchronous to the system clock. Each passes through a synchronizer chain, and serial clock edges are detected in the system domain, so the system clock must run several times faster than the serial clock. A configuration input selects the policy for a byte that arrives while the register is still full. With overwrite off, the new byte is discarded and the old one is kept. With overwrite on, the newest byte always replaces the stored one, so a target at the end of a daisy chain sees only the last byte of a burst. Both policies raise the overflow flag.

System logic reads the stored byte from the data output and pulses a read strobe to release it. A separate clear pulse resets the overflow flag.

Top module: `spi_tgt_rxbuf`

## Requirements
- R1: After reset, the data output is 0x00 and both the full flag and the overflow flag are 0.
- R2: While chip-select is low, bits are sampled on rising serial clock edges, most significant bit first. The eighth bit completes a byte, which is written to the data output and sets the full flag.
- R3: With overwrite disabled (overwrite input = 0), a byte that completes while the full flag is 1 is discarded. The data output keeps the older byte and the overflow flag becomes 1.
- R4: With overwrite enabled (overwrite input = 1), a byte that completes while the full flag is 1 replaces the data output and also sets the overflow flag.
- R5: A one-cycle read strobe clears the full flag. The data output keeps its value.
- R6: Once set, the overflow flag stays 1 through reads and later bytes. Only a one-cycle pulse on the overflow clear input returns it to 0.
- R7: Raising chip-select before the eighth bit discards the bits received so far. The next frame starts a fresh byte at its first bit.
- R8: A byte that completes while the full flag is 0 never sets the overflow flag, under either policy.
- R9: Serial clock edges while chip-select is high shift nothing and change neither the data output nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | Serial clock from the controller, idle low |
| spiMosi | input | 1 | Serial data from the controller |
| spiCsN | input | 1 | Active-low chip-select |
| overwriteEn | input | 1 | 1 = newest byte replaces unread data; 0 = unread data is kept |
| rdStb | input | 1 | One-cycle pulse that releases the held byte |
| ovfClr | input | 1 | One-cycle pulse that clears the overflow flag |
| rxData | output | 8 | Held received byte |
| rxFull | output | 1 | Held byte not yet read |
| rxOvf | output | 1 | Sticky overflow flag |

## Verification
Single bytes sent into an empty buffer with alternating bit patterns such as 0xA5 confirm bit order and byte framing, separately from any policy effect. Back-to-back bytes sent without a read, first with overwrite off and then with overwrite on, are the only case where the two policies differ: the data output then shows either the first or the last byte of the burst, while overflow rises in both. A truncated frame followed by a full byte, and serial clock toggling with chip-select high, separate correct frame handling from stray bit accumulation. Seeded random bursts of one to three bytes, with random policy, reads and clears in between, then run the flag interplay against a bench model.

// File: rtl/spi_rxbuf_pkg.sv
package spi_rxbuf_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic shiftEn;    // sample one serial bit this cycle
    logic byteDone;   // this sampled bit completes a byte
    logic frameReset; // chip-select inactive: drop partial state
  } ctlStrobes_t;

endpackage

// File: rtl/spi_rxbuf_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module spi_rxbuf_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RESET_VAL;
          else        chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RESET_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/spi_rxbuf_ctrl.sv
// Control half: serial clock edge detection and bit counting.
module spi_rxbuf_ctrl
  import spi_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sckS,
  input  logic        csNS,
  output ctlStrobes_t stb
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic             sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             sckRise;
  logic             csActive;

  always_comb begin
    sckRise        = sckS & ~sckPrev;
    csActive       = ~csNS;
    stb.frameReset = ~csActive;
    stb.shiftEn    = sckRise & csActive;
    stb.byteDone   = stb.shiftEn && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPrev <= 1'b0;
      bitCnt  <= '0;
    end else begin
      sckPrev <= sckS;
      if (stb.frameReset)    bitCnt <= '0;
      else if (stb.byteDone) bitCnt <= '0;
      else if (stb.shiftEn)  bitCnt <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_rxbuf_dpath.sv
// Datapath half: shift register, holding register and flags.
module spi_rxbuf_dpath
  import spi_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       stb,
  input  logic              mosiS,
  input  logic              overwriteEn,
  input  logic              rdStb,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOvf
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] nextByte;
  logic              fullNow;
  logic              takeByte;
  logic              collide;

  always_comb begin
    nextByte = {shiftReg[DATA_W-2:0], mosiS};
    // A read in the same cycle counts as already having freed the buffer
    fullNow  = rxFull & ~rdStb;
    collide  = stb.byteDone & fullNow;
    takeByte = stb.byteDone & (~fullNow | overwriteEn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shiftReg <= '0;
    else if (stb.frameReset) shiftReg <= '0;
    else if (stb.shiftEn)    shiftReg <= nextByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rxData <= '0;
    else if (takeByte) rxData <= nextByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rxFull <= 1'b0;
    else if (stb.byteDone) rxFull <= 1'b1;
    else if (rdStb)        rxFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rxOvf <= 1'b0;
    else if (collide) rxOvf <= 1'b1;
    else if (ovfClr)  rxOvf <= 1'b0;
  end

endmodule

// File: rtl/spi_tgt_rxbuf.sv
// SPI target receiver, mode 0, with a one-entry buffer and overwrite policy.
module spi_tgt_rxbuf
  import spi_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSck,
  input  logic              spiMosi,
  input  logic              spiCsN,
  input  logic              overwriteEn,
  input  logic              rdStb,
  input  logic              ovfClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOvf
);

  // Bit order in the synchronized vector: {csN, mosi, sck}
  localparam logic [2:0] SYNC_RESET = 3'b100;

  logic [2:0]  syncVec;
  ctlStrobes_t ctlStb;

  spi_rxbuf_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(SYNC_RESET)
  ) u_sync (
    .clk(clk),
    .rst_n(rst_n),
    .asyncIn({spiCsN, spiMosi, spiSck}),
    .syncOut(syncVec)
  );

  spi_rxbuf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .sckS(syncVec[0]),
    .csNS(syncVec[2]),
    .stb(ctlStb)
  );

  spi_rxbuf_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk),
    .rst_n(rst_n),
    .stb(ctlStb),
    .mosiS(syncVec[1]),
    .overwriteEn(overwriteEn),
    .rdStb(rdStb),
    .ovfClr(ovfClr),
    .rxData(rxData),
    .rxFull(rxFull),
    .rxOvf(rxOvf)
  );

endmodule

// File: rtl/spi_rxbuf_chk.sv
module spi_rxbuf_chk
  import spi_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input ctlStrobes_t       stb,
  input logic              overwriteEn,
  input logic              rdStb,
  input logic              ovfClr,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              rxOvf
);

  // R2
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxFull) |-> $past(stb.byteDone));

  // R3
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.byteDone && rxFull && !rdStb && !overwriteEn) |=> ($stable(rxData) && rxOvf));

  // R4
  overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.byteDone && rxFull && !rdStb && overwriteEn) |=> (rxOvf && rxFull));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && !stb.byteDone) |=> (!rxFull && $stable(rxData)));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxOvf && !ovfClr) |=> rxOvf);

  // R8
  no_false_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxOvf && !(stb.byteDone && rxFull && !rdStb)) |=> !rxOvf);

  // R9
  idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.frameReset |-> !stb.shiftEn);

endmodule

bind spi_tgt_rxbuf spi_rxbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .stb(ctlStb),
  .overwriteEn(overwriteEn),
  .rdStb(rdStb),
  .ovfClr(ovfClr),
  .rxData(rxData),
  .rxFull(rxFull),
  .rxOvf(rxOvf)
);

// File: tb/spi_tgt_rxbuf_test.sv
`timescale 1ns/1ps
module spi_tgt_rxbuf_test;

  localparam int HALF = 4; // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spiSck = 1'b0;
  logic       spiMosi = 1'b0;
  logic       spiCsN = 1'b1;
  logic       overwriteEn = 1'b0;
  logic       rdStb = 1'b0;
  logic       ovfClr = 1'b0;
  logic [7:0] rxData;
  logic       rxFull;
  logic       rxOvf;

  int checks = 0;
  int failures = 0;
  logic [7:0] expBuf = 8'h00;
  logic       expFull = 1'b0;
  logic       expOvf = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  spi_tgt_rxbuf uut (
    .clk(clk), .rst_n(rst_n), .spiSck(spiSck), .spiMosi(spiMosi),
    .spiCsN(spiCsN), .overwriteEn(overwriteEn), .rdStb(rdStb),
    .ovfClr(ovfClr), .rxData(rxData), .rxFull(rxFull), .rxOvf(rxOvf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench model of one completed byte
  function automatic void modelByte(input logic [7:0] b, input logic ow);
    if (expFull) expOvf = 1'b1;
    if (!expFull || ow) expBuf = b;
    expFull = 1'b1;
  endfunction

  task automatic sendBits(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      spiMosi = b[i];
      waitClk(HALF);
      spiSck = 1'b1;
      waitClk(HALF);
      spiSck = 1'b0;
    end
  endtask

  task automatic frameStart();
    spiCsN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic frameEnd();
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(6);
  endtask

  task automatic sendByteFrame(input logic [7:0] b);
    frameStart();
    sendBits(b, 8);
    modelByte(b, overwriteEn);
    frameEnd();
  endtask

  task automatic doRead();
    rdStb = 1'b1;
    waitClk(1);
    rdStb = 1'b0;
    expFull = 1'b0;
    waitClk(2);
  endtask

  task automatic doClear();
    ovfClr = 1'b1;
    waitClk(1);
    ovfClr = 1'b0;
    expOvf = 1'b0;
    waitClk(2);
  endtask

  task automatic checkAll(input string req);
    check({req, " data"}, {24'd0, rxData}, {24'd0, expBuf});
    check({req, " full"}, {31'd0, rxFull}, {31'd0, expFull});
    check({req, " ovf"}, {31'd0, rxOvf}, {31'd0, expOvf});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] bytes [3];
    void'($urandom(32'd20240611));
    waitClk(3);
    // R1: reset state
    checkAll("R1");
    rst_n = 1'b1;
    waitClk(3);
    checkAll("R1");

    // R2: single byte into empty buffer, MSB first
    sendByteFrame(8'hA5);
    checkAll("R2");
    // R8: no overflow on a byte into an empty buffer
    check("R8 ovf", {31'd0, rxOvf}, 32'd0);

    // R3: second byte while full, overwrite off -> old kept, ovf set
    sendByteFrame(8'h3C);
    check("R3 data", {24'd0, rxData}, 32'hA5);
    check("R3 ovf", {31'd0, rxOvf}, 32'd1);

    // R5: read clears full, data kept
    doRead();
    check("R5 full", {31'd0, rxFull}, 32'd0);
    check("R5 data", {24'd0, rxData}, 32'hA5);
    // R6: overflow survives read and another byte
    check("R6 ovf after read", {31'd0, rxOvf}, 32'd1);
    sendByteFrame(8'h5A);
    check("R6 ovf after byte", {31'd0, rxOvf}, 32'd1);
    doClear();
    check("R6 ovf after clear", {31'd0, rxOvf}, 32'd0);

    // R4: overwrite on, burst of three bytes in one frame keeps last
    overwriteEn = 1'b1;
    doRead();
    frameStart();
    sendBits(8'h11, 8); modelByte(8'h11, 1'b1);
    sendBits(8'h22, 8); modelByte(8'h22, 1'b1);
    sendBits(8'h33, 8); modelByte(8'h33, 1'b1);
    frameEnd();
    check("R4 data", {24'd0, rxData}, 32'h33);
    check("R4 ovf", {31'd0, rxOvf}, 32'd1);
    check("R4 full", {31'd0, rxFull}, 32'd1);
    doRead();
    doClear();

    // R7: partial frame dropped
    frameStart();
    sendBits(8'hFF, 5);
    frameEnd();
    checkAll("R7 partial");
    sendByteFrame(8'h0F);
    check("R7 data", {24'd0, rxData}, 32'h0F);
    check("R8 ovf after partial", {31'd0, rxOvf}, 32'd0);
    doRead();

    // R9: serial clock toggles while chip-select high
    spiMosi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      waitClk(HALF); spiSck = 1'b1;
      waitClk(HALF); spiSck = 1'b0;
    end
    waitClk(6);
    checkAll("R9");
    sendByteFrame(8'h81);
    check("R9 next byte", {24'd0, rxData}, 32'h81);
    doRead();

    // Random bursts against the bench model (R2 R3 R4 R5 R6 R8)
    for (int it = 0; it < 30; it++) begin
      int n;
      overwriteEn = 1'($urandom % 2);
      n = 1 + int'($urandom % 3);
      frameStart();
      for (int k = 0; k < n; k++) begin
        bytes[k] = 8'($urandom);
        sendBits(bytes[k], 8);
        modelByte(bytes[k], overwriteEn);
      end
      frameEnd();
      checkAll(overwriteEn ? "R4 rnd" : "R3 rnd");
      if ($urandom % 2 == 0) begin
        doRead();
        checkAll("R5 rnd");
      end
      if ($urandom % 4 == 0) begin
        doClear();
        checkAll("R6 rnd");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule